// File: doc/BRIEF.md
# Path Trace Capture Buffer

This block keeps a running copy of the path trace byte carried once per frame in the received path overhead. On each frame strobe, the incoming byte is written into a 64-entry circular byte store at the current write position, and the write position then moves on by one. In the same cycle, the incoming byte is compared with the byte already held at that position. A difference sets a sticky mismatch flag. Software can therefore read the whole trace once, and read it again only after the flag reports that it has changed.

Path defects freeze the buffer. While path AIS or path loss of pointer is present, frame strobes do not write, do not advance the position and do not set the flag. The flag output is also held low for as long as the defect lasts. A combinational read port returns any entry, chosen by a 6-bit index, at any time, without regard to the write position.

Top module: `trace_hist_buf`

## Requirements
- R1: After reset, every one of the 64 entries reads as 0x00 and the mismatch output is 0.
- R2: Each frame strobe taken with no defect present writes the byte into the entry at the write position. The position starts at 0 after reset, steps by one per accepted strobe, and wraps from 63 to 0.
- R3: rd_data equals the entry chosen by rd_addr in the same cycle, for any address, whatever the write position.
- R4: An accepted strobe whose byte differs from the old contents of the entry being written sets the flag. The flag is visible on the mismatch output from the next clock edge on.
- R5: An accepted strobe whose byte equals the stored entry leaves a clear flag clear.
- R6: The flag stays set until a clr_flag pulse clears it at the next edge. If a setting strobe and a clear arrive in the same cycle, the flag ends up set.
- R7: While path_ais or path_lop is high, the mismatch output is 0. A flag set earlier reappears once both defects are gone.
- R8: A frame strobe while path_ais or path_lop is high changes no entry, does not advance the write position and does not set the flag.
- R9: Cycles with no frame strobe change no entry and do not set the flag, whatever rx_byte carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received path trace byte |
| frame_stb | input | 1 | One-cycle pulse, one per frame, qualifying rx_byte |
| path_ais | input | 1 | Path AIS defect present |
| path_lop | input | 1 | Path loss of pointer defect present |
| rd_addr | input | 6 | Read index into the trace store |
| clr_flag | input | 1 | Clears the sticky mismatch flag |
| rd_data | output | 8 | Entry at rd_addr (combinational) |
| mismatch | output | 1 | Sticky mismatch flag, masked during defects |

## Verification
On every cycle, the assertions check four things. The write position steps or holds as required. No write happens during a defect. An accepted write lands in the entry it addressed. The flag sets, holds and clears according to the compare event and the clear pulse. Only the bench's scenarios can show the rest. The whole 64-entry content is read back after full passes and after wrap-around. A defect-time strobe leaves the trace and the position untouched, which shows up in where the next accepted byte lands. The masked flag returns once the defect ends.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_CAPTURE = 2'd1,
    ACT_FROZEN  = 2'd2
  } wr_act_t;

  function automatic logic in_defect(input logic ais, input logic lop);
    return ais | lop;
  endfunction

  function automatic wr_act_t decode_act(input logic stb, input logic ais, input logic lop);
    if (!stb) return ACT_IDLE;
    if (in_defect(ais, lop)) return ACT_FROZEN;
    return ACT_CAPTURE;
  endfunction
endpackage

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_stb,
  input  logic          path_ais,
  input  logic          path_lop,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] old_byte,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          diff_evt
);
  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  function automatic logic bytes_differ(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return |(a ^ b);
  endfunction

  wr_act_t       act;
  logic [AW-1:0] ptr_q;

  assign act      = decode_act(frame_stb, path_ais, path_lop);
  assign wr_en    = (act == ACT_CAPTURE);
  assign wr_addr  = ptr_q;
  assign diff_evt = wr_en && bytes_differ(rx_byte, old_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (wr_en) ptr_q <= step_ptr(ptr_q);
  end

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !path_ais && !path_lop) |=> (ptr_q == step_ptr($past(ptr_q))));

  p_ptr_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && (path_ais || path_lop)) |=> $stable(ptr_q));

  p_ptr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(ptr_q));
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cmp_data
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) mem[i] <= '0;
      else if (wr_en && (wr_addr == AW'(i))) mem[i] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign cmp_data = mem[wr_addr];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (mem[$past(rd_addr)] == $past(rd_data)));
endmodule

// File: rtl/trace_flag.sv
module trace_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag_q);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_evt) |=> !flag_q);
endmodule

// File: rtl/trace_hist_buf.sv
module trace_hist_buf
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_byte,
  input  logic          frame_stb,
  input  logic          path_ais,
  input  logic          path_lop,
  input  logic [AW-1:0] rd_addr,
  input  logic          clr_flag,
  output logic [DW-1:0] rd_data,
  output logic          mismatch
);
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          diff_evt;
  logic [DW-1:0] cmp_data;
  logic          flag_q;

  trace_wr_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .path_ais(path_ais), .path_lop(path_lop),
    .rx_byte(rx_byte), .old_byte(cmp_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .diff_evt(diff_evt)
  );

  trace_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(rx_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp_data(cmp_data)
  );

  trace_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(diff_evt), .clr(clr_flag),
    .flag_q(flag_q)
  );

  assign mismatch = flag_q & ~in_defect(path_ais, path_lop);

  p_defect_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (path_ais || path_lop) |-> !wr_en);

  p_defect_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (path_ais || path_lop) |-> !diff_evt);

  p_flag_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(path_ais || path_lop) && $past(flag_q) && !$past(clr_flag)) |-> mismatch);
endmodule

// File: tb/trace_hist_buf_bench.sv
`timescale 1ns/1ps
module trace_hist_buf_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] rx_byte = '0;
  logic       frame_stb = 0, path_ais = 0, path_lop = 0, clr_flag = 0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       mismatch;

  int checks = 0, failures = 0;
  logic [7:0] m_mem [64];
  int         m_ptr = 0;
  logic       m_flag = 0;

  always #2 clk = ~clk;

  trace_hist_buf u_trace_hist_buf (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .frame_stb(frame_stb),
    .path_ais(path_ais), .path_lop(path_lop), .rd_addr(rd_addr),
    .clr_flag(clr_flag), .rd_data(rd_data), .mismatch(mismatch)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int i, int k);
    return 8'((i * 37 + k * 11 + 5) & 255);
  endfunction

  // one cycle: optional strobe and clear, model updated per the requirements
  task automatic cycle(logic stb, logic [7:0] b, logic clr);
    logic setv;
    @(negedge clk);
    rx_byte = b; frame_stb = stb; clr_flag = clr;
    setv = 0;
    if (stb && !path_ais && !path_lop) begin
      if (m_mem[m_ptr] != b) setv = 1;
      m_mem[m_ptr] = b;
      m_ptr = (m_ptr + 1) % 64;
    end
    if (setv) m_flag = 1; else if (clr) m_flag = 0;
    @(negedge clk);
    frame_stb = 0; clr_flag = 0;
  endtask

  task automatic check_mem(string req);
    int bad = 0;
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a); #0.5;
      if (rd_data != m_mem[a]) begin
        bad++;
        if (bad == 1) chk(req, rd_data, m_mem[a]);
      end
    end
    if (bad == 0) chk(req, 0, 0);
  endtask

  function automatic int exp_mis();
    return (m_flag && !path_ais && !path_lop) ? 1 : 0;
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_mem("R1");
    chk("R1", mismatch, 0);

    // R2/R4 first full pass: every position written, old contents were zero
    for (int i = 0; i < 64; i++) cycle(1, pat(i, 0), 0);
    check_mem("R2");
    chk("R4", mismatch, exp_mis());
    chk("R4", mismatch, 1);
    cycle(0, 8'h00, 1);
    chk("R6", mismatch, 0);

    // R5 identical second pass after wrap: no flag
    for (int i = 0; i < 64; i++) cycle(1, pat(i, 0), 0);
    chk("R5", mismatch, 0);
    check_mem("R5");

    // R2 wrap: next byte lands in entry 0, differs -> R4
    cycle(1, ~pat(0, 0), 0);
    rd_addr = 6'd0; #0.5;
    chk("R2", rd_data, 8'(~pat(0, 0)));
    chk("R4", mismatch, 1);
    cycle(0, 8'h55, 0);
    chk("R6", mismatch, 1);

    // R3 reads independent of write position, random-ish order
    for (int a = 63; a >= 0; a -= 7) begin
      rd_addr = 6'(a); #0.5;
      chk("R3", rd_data, m_mem[a]);
    end

    // R7/R8 under AIS: masked, strobe ignored
    @(negedge clk); path_ais = 1; #0.5;
    chk("R7", mismatch, 0);
    cycle(1, 8'hA5, 0);
    chk("R7", mismatch, 0);
    check_mem("R8");
    @(negedge clk); path_ais = 0; #0.5;
    chk("R7", mismatch, exp_mis());
    chk("R7", mismatch, 1);
    cycle(0, 8'h00, 1);
    chk("R6", mismatch, 0);

    // R8 under LOP: strobe with differing byte neither writes nor sets
    @(negedge clk); path_lop = 1;
    cycle(1, 8'h3C, 0);
    cycle(1, 8'hC3, 0);
    @(negedge clk); path_lop = 0; #0.5;
    chk("R8", mismatch, 0);
    check_mem("R8");
    // position must still be 1: next accepted byte lands in entry 1
    cycle(1, pat(1, 0), 0);
    chk("R8", mismatch, 0);
    cycle(1, 8'h7E, 0);
    rd_addr = 6'd2; #0.5;
    chk("R8", rd_data, 8'h7E);
    chk("R4", mismatch, 1);

    // R6 set beats clear in the same cycle
    cycle(0, 8'h00, 1);
    chk("R6", mismatch, 0);
    cycle(1, ~m_mem[3], 1);
    chk("R6", mismatch, 1);
    cycle(0, 8'h00, 1);

    // R9 no strobe: bytes on rx_byte ignored
    for (int i = 0; i < 10; i++) cycle(0, pat(i, 3), 0);
    chk("R9", mismatch, 0);
    check_mem("R9");

    // R4/R5 third pass with mixed changes, per-position flag behaviour
    for (int k = 1; k < 4; k++) begin
      for (int i = 0; i < 64; i++) begin
        logic [7:0] b;
        b = (i % k == 0) ? pat(i, k) : m_mem[m_ptr];
        cycle(1, b, 0);
        chk((k == 1) ? "R4" : "R5", mismatch, exp_mis());
        cycle(0, 8'h00, 1);
      end
    end
    check_mem("R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule